// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a 32-bit record of why the system last came out of reset, and lets software ask for a new reset by writing to it. Five bits at the top of the word carry the causes. A power-on flag is set by hardware the first time a system reset is seen after power-up. Two software flags, a software power-on request and a software warm-reset request, are set only by software writes. Two button flags are never set here, but software can clear them. All other bits always read zero.

Software reaches the register through a simple one-word access port. The register sits in the upper word of an 8-byte slot, and the lower word of that slot reads zero. A write that sets either software flag produces a single-cycle `rst_req_o` pulse toward the reset distribution logic. An internal saturating counter counts the system resets seen since power-up. When a system reset arrives while the count is zero, the register is reloaded with only the power-on flag set. A software power-on request zeroes the count, so the next system reset looks like a power-on again.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the register reads 0x00000000, `rst_req_o` is low and the internal reset count is zero.
- R2: Bits 26:0 always read zero. Write data bits 26:0 have no effect on the register, the count or `rst_req_o`.
- R3: The power-on flag (bit 31), the button power-on flag (bit 28) and the button warm-reset flag (bit 27) are write-one-to-clear. Writing 0 to them leaves them unchanged, and software can never set them.
- R4: The software power-on flag (bit 30) and the software warm-reset flag (bit 29) are set by writing 1. Writing 0 leaves them unchanged, so once set they stay set until a power-on reload.
- R5: A write with bit 30 set zeroes the reset count. A write with only bit 29 set leaves the count unchanged.
- R6: `rst_req_o` is high for exactly the one cycle that follows an accepted upper-word write with bit 30 or bit 29 set. This includes a write with both bits set, which gives one pulse. In every other cycle `rst_req_o` is low.
- R7: A cycle with `sys_rst_i` high while the count is zero loads the register with exactly 0x80000000. When the count is nonzero, `sys_rst_i` leaves the register unchanged. Each `sys_rst_i` cycle increments the count.
- R8: `acc_word_i` = 1 selects the register, which is the upper word. `acc_word_i` = 0 selects the lower word, which reads 0x00000000 and ignores writes.
- R9: The reset count saturates at 2**CNT_W-1 and never wraps back to zero. After any number of further system resets without a software power-on request, the register is not reloaded.
- R10: When `sys_rst_i` and a write occur in the same cycle, the system reset is applied and the write is dropped entirely: there is no flag change, no count clear and no request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset of the block |
| sys_rst_i | input | 1 | One cycle per system reset event |
| acc_en_i | input | 1 | Access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_word_i | input | 1 | Word select in the slot: 1 = upper (register), 0 = lower |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data (combinational, valid during a read access) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The flags are tried with single-bit writes, all-ones writes, writes of zero and writes confined to the reserved bits. These separate write-one-to-clear behaviour from set-only behaviour and from bits that must be ignored. Reset sequences are run with the count at zero, at a nonzero value, after a software power-on request and after a software warm-reset request. This shows whether the power-on reload depends on the count, and whether only bit 30 rearms it. A run of twenty system resets from a cleared register shows whether the counter wraps. A write that coincides with a system reset shows which of the two wins. Lower-word accesses and a mid-run power-up reset complete the patterns.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned BIT_POR    = 31;
  localparam int unsigned BIT_SW_POR = 30;
  localparam int unsigned BIT_SW_WRM = 29;
  localparam int unsigned BIT_BT_POR = 28;
  localparam int unsigned BIT_BT_WRM = 27;
  localparam int unsigned CAUSE_LO   = BIT_BT_WRM;

  localparam logic [REG_W-1:0] POR_VALUE = REG_W'(1) << BIT_POR;

  typedef enum logic [1:0] {
    FK_RSVD = 2'd0,
    FK_W1C  = 2'd1,
    FK_W1S  = 2'd2
  } field_kind_e;

  function automatic field_kind_e field_kind(input int unsigned pos);
    if (pos == BIT_SW_POR || pos == BIT_SW_WRM) return FK_W1S;
    if (pos == BIT_POR || pos == BIT_BT_POR || pos == BIT_BT_WRM) return FK_W1C;
    return FK_RSVD;
  endfunction

endpackage

// File: rtl/rst_cause_bit.sv
module rst_cause_bit
  import rst_cause_pkg::*;
#(
  parameter field_kind_e KIND     = FK_W1C,
  parameter logic        LOAD_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else if (load_i) begin
      q_q <= LOAD_VAL;
    end else if (wr_i && wbit_i) begin
      q_q <= (KIND == FK_W1S);
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/rst_cause_cnt.sv
module rst_cause_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end else if (clr_i) begin
      cnt_q <= '0;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/rst_cause_req.sv
module rst_cause_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);

  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= fire_i;
  end

  assign req_o = req_q;

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             acc_en_i,
  input  logic             acc_we_i,
  input  logic             acc_word_i,
  input  logic [REG_W-1:0] acc_wdata_i,
  output logic [REG_W-1:0] acc_rdata_o,
  output logic             rst_req_o
);

  logic             wr_hit;
  logic             por_load;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] cause_q;
  logic             unused_wdata;

  // system reset wins over a same-cycle write
  assign wr_hit   = acc_en_i && acc_we_i && acc_word_i && !sys_rst_i;
  assign por_load = sys_rst_i && cnt_zero;

  assign unused_wdata = ^acc_wdata_i[CAUSE_LO-1:0];

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (field_kind(i) == FK_RSVD) begin : g_rsvd
      assign cause_q[i] = 1'b0;
    end else begin : g_cell
      rst_cause_bit #(
        .KIND     (field_kind(i)),
        .LOAD_VAL (POR_VALUE[i])
      ) u_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (por_load),
        .wr_i   (wr_hit),
        .wbit_i (acc_wdata_i[i]),
        .q_o    (cause_q[i])
      );
    end
  end

  rst_cause_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sys_rst_i),
    .clr_i  (wr_hit && acc_wdata_i[BIT_SW_POR]),
    .zero_o (cnt_zero),
    .cnt_o  (cnt_q)
  );

  rst_cause_req u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_hit && (acc_wdata_i[BIT_SW_POR] || acc_wdata_i[BIT_SW_WRM])),
    .req_o  (rst_req_o)
  );

  assign acc_rdata_o = (acc_en_i && !acc_we_i && acc_word_i) ? cause_q : '0;

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
  import rst_cause_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic             acc_en_i,
  input logic             acc_we_i,
  input logic             acc_word_i,
  input logic [REG_W-1:0] acc_wdata_i,
  input logic [REG_W-1:0] cause_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rst_req_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic up_wr, lo_wr;
  assign up_wr = acc_en_i && acc_we_i && acc_word_i;
  assign lo_wr = acc_en_i && acc_we_i && !acc_word_i;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_q[CAUSE_LO-1:0] == '0); // R2

  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(up_wr && !sys_rst_i &&
                        (acc_wdata_i[BIT_SW_POR] || acc_wdata_i[BIT_SW_WRM]))); // R6

  AST_POR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && cnt_q == '0) |=> (cause_q == POR_VALUE)); // R7

  AST_SW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q[BIT_SW_WRM] && !sys_rst_i) |=> cause_q[BIT_SW_WRM]); // R4

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && sys_rst_i) |=> (cnt_q == CNT_MAX)); // R9

  AST_LOW_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr && !sys_rst_i) |=> $stable(cause_q)); // R8

  AST_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_wr && sys_rst_i) |=> !rst_req_o); // R10

endmodule

bind rst_cause_reg rst_cause_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_i   (sys_rst_i),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_word_i  (acc_word_i),
  .acc_wdata_i (acc_wdata_i),
  .cause_q     (cause_q),
  .cnt_q       (cnt_q),
  .rst_req_o   (rst_req_o)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;

  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic        acc_en_i = 1'b0;
  logic        acc_we_i = 1'b0;
  logic        acc_word_i = 1'b0;
  logic [31:0] acc_wdata_i = '0;
  logic [31:0] acc_rdata_o;
  logic        rst_req_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_reg = '0;
  int          m_cnt = 0;
  logic        m_req = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_reg #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i),
    .acc_en_i(acc_en_i), .acc_we_i(acc_we_i), .acc_word_i(acc_word_i),
    .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // R6: request output compared with the model every cycle
  always @(negedge clk) if (!done) check("R6 rst_req_o", {31'd0, rst_req_o}, {31'd0, m_req});

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input bit en, input bit we, input bit word, input logic [31:0] wd, input bit sys);
    logic [31:0] v;
    @(negedge clk);
    acc_en_i = en; acc_we_i = we; acc_word_i = word; acc_wdata_i = wd; sys_rst_i = sys;
    @(posedge clk);
    if (sys) begin
      if (m_cnt == 0) m_reg = 32'h8000_0000;
      if (m_cnt < CNT_MAX) m_cnt++;
      m_req = 1'b0;
    end else if (en && we && word) begin
      v = wd & 32'hF800_0000;
      m_reg = m_reg & ~(v & 32'h9800_0000);
      m_reg = m_reg | (v & 32'h6000_0000);
      if (v[30]) m_cnt = 0;
      m_req = v[30] | v[29];
    end else begin
      m_req = 1'b0;
    end
    #0.5;
    acc_en_i = 1'b0; acc_we_i = 1'b0; sys_rst_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);  step(1, 1, 1, d, 0); endtask
  task automatic sysrst();                  step(0, 0, 0, '0, 1); endtask

  task automatic rd(input string tag, input bit word, input logic [31:0] exp);
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = 1'b0; acc_word_i = word; sys_rst_i = 1'b0;
    #1;
    check(tag, acc_rdata_o, exp);
    @(posedge clk);
    m_req = 1'b0;
    #0.5;
    acc_en_i = 1'b0;
  endtask

  task automatic por();
    @(negedge clk);
    rst_ni = 1'b0;
    m_reg = '0; m_cnt = 0; m_req = 1'b0;
    #1;
    check("R1 reg during reset", uut.acc_rdata_o | 32'h0, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd("R1 reset value", 1, 32'h0);
    rd("R8 lower word after reset", 0, 32'h0);

    sysrst();
    rd("R7 first sys reset loads power-on", 1, 32'h8000_0000);
    rd("R8 lower word reads zero", 0, 32'h0);
    sysrst();
    rd("R7 second sys reset no change", 1, 32'h8000_0000);

    wr(32'h0000_0000);
    rd("R3 write zero keeps bit31", 1, 32'h8000_0000);
    wr(32'h8000_0000);
    rd("R3 write one clears bit31", 1, 32'h0);
    wr(32'h1800_0000);
    rd("R3 button bits not settable", 1, 32'h0);
    sysrst();
    rd("R7 nonzero count no reload", 1, 32'h0);

    step(1, 1, 0, 32'hFFFF_FFFF, 0);
    rd("R8 lower word write ignored", 1, 32'h0);
    wr(32'h07FF_FFFF);
    rd("R2 reserved data discarded", 1, 32'h0);

    wr(32'h2000_0000);
    rd("R4 sw warm bit set", 1, 32'h2000_0000);
    wr(32'h0000_0000);
    rd("R4 sw warm bit sticky", 1, 32'h2000_0000);
    wr(32'hBFFF_FFFF);
    rd("R4 all-ones but bit30 keeps bit29", 1, 32'h2000_0000);
    sysrst();
    rd("R5 warm request leaves count", 1, 32'h2000_0000);

    wr(32'h4000_0000);
    rd("R4 sw power-on bit set", 1, 32'h6000_0000);
    sysrst();
    rd("R5 power-on request rearms reload", 1, 32'h8000_0000);
    sysrst();
    rd("R7 after rearm only one reload", 1, 32'h8000_0000);

    wr(32'h6000_0000);
    rd("R6 both software bits", 1, 32'hE000_0000);
    sysrst();
    rd("R5 combined write cleared count", 1, 32'h8000_0000);

    wr(32'h8000_0000);
    for (int i = 0; i < 20; i++) sysrst();
    rd("R9 count saturates, no wrap reload", 1, 32'h0);

    step(1, 1, 1, 32'h6000_0000, 1);
    rd("R10 write dropped on sys reset", 1, 32'h0);
    sysrst();
    rd("R10 dropped write did not clear count", 1, 32'h0);

    por();
    rd("R1 reset value after mid-run reset", 1, 32'h0);
    sysrst();
    rd("R1 count zero after reset", 1, 32'h8000_0000);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule